// File: doc/BRIEF.md
# Framed register-write command receiver

This block sits behind a byte-oriented serial receiver and turns a stream of bytes into register writes. The host wraps its requests in frames. A frame opens with a fixed five-byte sync pattern. Then come zero or more two-byte operations, and a single closing byte ends the frame. Each operation names an 8-bit register address and carries an 8-bit data value. The receiver holds a frame's operations back until the closing byte arrives. Once the frame closes, it applies them in order, one per clock, to a small banked register file. That file holds the control registers, the clock-rate pair, a staged DAC word and the protocol-trigger match, mask and mode settings.

The register bank that later operations see is chosen by a field of a control register. A frame can therefore switch banks, program the trigger settings and switch back. An operation that addresses the status location in the default bank is a read. It returns one byte, taken from the `status_in` input, on the transmit side. A frame that runs past the operation limit without its closing byte is dropped whole, and nothing from it reaches the registers. Frames may follow each other with no idle bytes in between, and bytes may arrive on consecutive clocks.

Top module: `cmd_frame_rx`

## Requirements
- R1: The parser stays in sync search until it sees the bytes 0x40, 0x4C, 0x44, 0x53, 0x7E in that order. A byte that breaks the sequence restarts the search. If that byte is 0x40, it counts as the first sync byte. Bytes received during the search change no register.
- R2: After the sync bytes, each operation is two bytes: the address first, then the data. A frame with N operations is 2N+6 bytes long, and N may be anything from 0 to MAX_OPS (default 8).
- R3: A byte of 0x7E received where an operation's address byte is due closes the frame, so address 0x7E is never written. If the closing byte is accepted at clock edge k and no earlier frame is still draining, operation i (counting from 0) takes effect at edge k+1+i. The outputs show it in the cycle after that edge.
- R4: After MAX_OPS operations, any byte other than 0x7E aborts the frame. None of that frame's operations is applied, and the aborting byte is then treated as a possible first sync byte.
- R5: The bank-select register sits at address 0x0F and can be written in every bank; it appears on `ctl2`. Its bits [1:0] select the bank for every later operation, including later operations of the same frame. Its reset value is 0, which selects bank 0.
- R6: In bank 0, address 0x09 writes the high byte and 0x0A the low byte of `clk_rate`. Address 0x0B writes `ctl1`.
- R7: In bank 0, address 0x0C stages the DAC high byte and 0x0D stages the low byte. `dac_value` changes only when `ctl1` is written with bit 5 set. At that point it takes {high, low} from the staged bytes, both at once.
- R8: In bank 2, addresses 0x00 to 0x03 write match byte 0 to 3 (`trig_match[8i+7:8i]`), addresses 0x04 to 0x07 write mask byte 0 to 3 (`trig_mask`), and address 0x08 writes `spi_mode`. Operations in bank 2 leave the bank-0 registers unchanged. Operations in bank 1 or 3, apart from the bank-select write, have no effect.
- R9: An operation at address 0x02 in bank 0 is a status read. Its data byte is ignored. `tx_valid` goes high for exactly the one cycle that follows the edge that applies the operation, and `tx_byte` then holds the `status_in` value sampled at that edge. No other operation raises `tx_valid`.
- R10: Frames sent back to back, with bytes on consecutive clocks, are all applied in arrival order, and no operation is lost.
- R11: After a synchronous active-low reset, all registers, `dac_value` and `tx_valid` are 0, and the parser is in sync search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| status_in | input | 8 | Status value returned by a status read |
| tx_valid | output | 1 | A reply byte is present this cycle |
| tx_byte | output | 8 | Reply byte |
| ctl1 | output | 8 | Control register 1 |
| ctl2 | output | 8 | Control register 2; bits [1:0] select the bank |
| clk_rate | output | 16 | Clock-rate pair {high, low} |
| dac_value | output | 16 | DAC output word |
| trig_match | output | 32 | Trigger match bytes, byte i at [8i+7:8i] |
| trig_mask | output | 32 | Trigger mask bytes, byte i at [8i+7:8i] |
| spi_mode | output | 8 | Protocol-trigger mode byte |

## Verification
Nothing changes while a frame is still being received. Operation i of a frame whose closing byte is accepted at edge k becomes visible after edge k+1+i, plus one cycle for each operation of an earlier frame that is still queued. A status reply appears in the same cycle as a register write would. The bench's reference model advances on each rising edge, with the same queueing delay worked out from the requirements. It compares every output at the falling edge, so each comparison falls in the cycle where the result is due. Directed checks after each scenario then compare the settled registers and the number of reply bytes with constants derived by hand.

// File: rtl/cfr_pkg.sv
// Shared constants and types for the framed command receiver.
// Assumes 8-bit bytes and 8-bit register addresses.
package cfr_pkg;

    localparam int          HDR_LEN      = 5;
    localparam logic [7:0]  END_BYTE     = 8'h7E;

    // Bank numbers
    localparam logic [1:0]  BANK_MAIN    = 2'd0;
    localparam logic [1:0]  BANK_TRIG    = 2'd2;

    // Addresses decoded in every bank
    localparam logic [7:0]  A_BANKSEL    = 8'h0F;

    // Bank 0 addresses
    localparam logic [7:0]  A_STATUS     = 8'h02;
    localparam logic [7:0]  A_RATE_HI    = 8'h09;
    localparam logic [7:0]  A_RATE_LO    = 8'h0A;
    localparam logic [7:0]  A_CTRL1      = 8'h0B;
    localparam logic [7:0]  A_DAC_HI     = 8'h0C;
    localparam logic [7:0]  A_DAC_LO     = 8'h0D;
    localparam int          DAC_LOAD_BIT = 5;

    // One decoded register operation
    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] data;
    } reg_op_t;

    typedef enum logic [1:0] {PS_HUNT, PS_BOUND, PS_LOW} parse_state_t;

    // Expected sync byte at a given position of the header
    function automatic logic [7:0] sync_byte(input logic [2:0] pos);
        case (pos)
            3'd0:    sync_byte = 8'h40;
            3'd1:    sync_byte = 8'h4C;
            3'd2:    sync_byte = 8'h44;
            3'd3:    sync_byte = 8'h53;
            default: sync_byte = 8'h7E;
        endcase
    endfunction

endpackage

// File: rtl/cfr_frame_parser.sv
// Frame parser: hunts for the five-byte sync pattern, then splits the
// payload into address/data operations. At each operation boundary a 0x7E
// closes the frame (commit). Any other byte after MAX_OPS operations
// aborts the frame.
// Assumes at most one byte per cycle, flagged by rx_valid.
module cfr_frame_parser
    import cfr_pkg::*;
#(
    parameter int MAX_OPS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    output logic        push,
    output reg_op_t     push_op,
    output logic        commit,
    output logic        abort
);
    localparam int CW = $clog2(MAX_OPS + 1);

    parse_state_t   state;
    logic [2:0]     hdr_pos;
    logic [CW-1:0]  op_cnt;
    logic [7:0]     addr_q;

    logic at_end, at_limit;
    assign at_end   = (rx_byte == END_BYTE);
    assign at_limit = (op_cnt == CW'(MAX_OPS));

    // Frame events seen by the operation queue
    assign push    = rx_valid && (state == PS_LOW);
    assign push_op = '{addr: addr_q, data: rx_byte};
    assign commit  = rx_valid && (state == PS_BOUND) && at_end;
    assign abort   = rx_valid && (state == PS_BOUND) && !at_end && at_limit;

    // Sync search and payload sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= PS_HUNT;
            hdr_pos <= '0;
            op_cnt  <= '0;
            addr_q  <= '0;
        end else if (rx_valid) begin
            case (state)
                PS_HUNT: begin
                    if (rx_byte == sync_byte(hdr_pos)) begin
                        if (hdr_pos == 3'(HDR_LEN - 1)) begin
                            state   <= PS_BOUND;
                            hdr_pos <= '0;
                            op_cnt  <= '0;
                        end else begin
                            hdr_pos <= hdr_pos + 3'd1;
                        end
                    end else begin
                        hdr_pos <= (rx_byte == sync_byte(3'd0)) ? 3'd1 : 3'd0;
                    end
                end
                PS_BOUND: begin
                    if (at_end) begin
                        state <= PS_HUNT;
                    end else if (at_limit) begin
                        state   <= PS_HUNT;
                        hdr_pos <= (rx_byte == sync_byte(3'd0)) ? 3'd1 : 3'd0;
                    end else begin
                        addr_q <= rx_byte;
                        state  <= PS_LOW;
                    end
                end
                default: begin
                    op_cnt <= op_cnt + CW'(1);
                    state  <= PS_BOUND;
                end
            endcase
        end
    end

    // R3
    close_to_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (state == PS_HUNT));

    // R4
    abort_to_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (state == PS_HUNT) && (op_cnt == CW'(MAX_OPS)));

endmodule

// File: rtl/cfr_op_fifo.sv
// Operation queue with a commit pointer. Operations of an open frame are
// written past the commit pointer and stay invisible to the reader until
// the frame closes. An abort rewinds the write pointer to the commit
// pointer, which drops the open frame. The reader drains one committed
// operation per pop.
// Assumes DEPTH is a power of two and large enough for one open frame plus
// one undrained frame.
module cfr_op_fifo
    import cfr_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push,
    input  reg_op_t  push_op,
    input  logic     commit,
    input  logic     abort,
    input  logic     pop,
    output logic     head_valid,
    output reg_op_t  head_op
);
    localparam int AW = $clog2(DEPTH);

    reg_op_t        mem [DEPTH];
    logic [AW:0]    wr_ptr, cm_ptr, rd_ptr;

    assign head_valid = (rd_ptr != cm_ptr);
    assign head_op    = mem[rd_ptr[AW-1:0]];

    // Operation storage
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr[AW-1:0]] <= push_op;
    end

    // Write, commit and read pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            cm_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (abort)      wr_ptr <= cm_ptr;
            else if (push)  wr_ptr <= wr_ptr + (AW+1)'(1);
            if (commit)     cm_ptr <= wr_ptr;
            if (pop)        rd_ptr <= rd_ptr + (AW+1)'(1);
        end
    end

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr - rd_ptr) <= (AW+1)'(DEPTH));

    // R3
    drain_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_ptr - rd_ptr) <= (wr_ptr - rd_ptr));

endmodule

// File: rtl/cfr_reg_file.sv
// Banked register file. It applies one committed operation per cycle. The
// bank-select register is decoded in every bank. Bank 0 holds the
// control, clock-rate and DAC registers and the status read. Bank 2 holds
// the trigger match/mask bytes and the mode byte. A status read produces a
// one-cycle reply.
// Assumes 2*NUM_PAT + 1 addresses fit below the bank-select address.
module cfr_reg_file
    import cfr_pkg::*;
#(
    parameter int NUM_PAT = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  op_valid,
    input  reg_op_t               op,
    input  logic [7:0]            status_in,
    output logic [7:0]            ctl1,
    output logic [7:0]            ctl2,
    output logic [15:0]           clk_rate,
    output logic [15:0]           dac_value,
    output logic [NUM_PAT*8-1:0]  trig_match,
    output logic [NUM_PAT*8-1:0]  trig_mask,
    output logic [7:0]            spi_mode,
    output logic                  tx_valid,
    output logic [7:0]            tx_byte
);
    localparam logic [7:0] A_MODE = 8'(2 * NUM_PAT);

    logic [1:0] bank;
    logic       is_sel, main_wr, trig_wr;
    logic [7:0] dac_hi_q, dac_lo_q;
    logic [7:0] match_q [NUM_PAT];
    logic [7:0] mask_q  [NUM_PAT];

    assign bank    = ctl2[1:0];
    assign is_sel  = op_valid && (op.addr == A_BANKSEL);
    assign main_wr = op_valid && !is_sel && (bank == BANK_MAIN);
    assign trig_wr = op_valid && !is_sel && (bank == BANK_TRIG);

    // Bank select, always reachable
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl2 <= '0;
        else if (is_sel) ctl2 <= op.data;
    end

    // Bank 0 registers and DAC transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl1      <= '0;
            clk_rate  <= '0;
            dac_hi_q  <= '0;
            dac_lo_q  <= '0;
            dac_value <= '0;
        end else if (main_wr) begin
            case (op.addr)
                A_RATE_HI: clk_rate[15:8] <= op.data;
                A_RATE_LO: clk_rate[7:0]  <= op.data;
                A_DAC_HI:  dac_hi_q       <= op.data;
                A_DAC_LO:  dac_lo_q       <= op.data;
                A_CTRL1: begin
                    ctl1 <= op.data;
                    if (op.data[DAC_LOAD_BIT]) dac_value <= {dac_hi_q, dac_lo_q};
                end
                default: ;
            endcase
        end
    end

    // Status reply, one byte per status read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_byte  <= '0;
        end else begin
            tx_valid <= main_wr && (op.addr == A_STATUS);
            if (main_wr && (op.addr == A_STATUS)) tx_byte <= status_in;
        end
    end

    // Bank 2 mode byte
    always_ff @(posedge clk) begin
        if (!rst_n)                            spi_mode <= '0;
        else if (trig_wr && op.addr == A_MODE) spi_mode <= op.data;
    end

    for (genvar g = 0; g < NUM_PAT; g++) begin : g_pat
        // Bank 2 match and mask byte g
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                match_q[g] <= '0;
                mask_q[g]  <= '0;
            end else if (trig_wr) begin
                if (op.addr == 8'(g))           match_q[g] <= op.data;
                if (op.addr == 8'(NUM_PAT + g)) mask_q[g]  <= op.data;
            end
        end
        assign trig_match[8*g +: 8] = match_q[g];
        assign trig_mask[8*g +: 8]  = mask_q[g];
    end

    // R7
    dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && bank == BANK_MAIN && op.addr == A_CTRL1 && op.data[DAC_LOAD_BIT])
        |=> $stable(dac_value));

    // R9
    status_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && bank == BANK_MAIN && op.addr == A_STATUS)
        |=> (tx_valid && tx_byte == $past(status_in)));

    // R8
    bank_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && bank == BANK_TRIG)
        |=> ($stable(clk_rate) && $stable(ctl1) && $stable(dac_value)));

endmodule

// File: rtl/cmd_frame_rx.sv
// Framed register-write command receiver, top level.
// Parser -> commit-pointer queue -> banked register file.
// Assumes byte-valid input from a serial receiver, at most one byte per
// cycle. The reply byte is presented for one cycle with no back-pressure.
module cmd_frame_rx
    import cfr_pkg::*;
#(
    parameter int MAX_OPS = 8,
    parameter int NUM_PAT = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_valid,
    input  logic [7:0]            rx_byte,
    input  logic [7:0]            status_in,
    output logic                  tx_valid,
    output logic [7:0]            tx_byte,
    output logic [7:0]            ctl1,
    output logic [7:0]            ctl2,
    output logic [15:0]           clk_rate,
    output logic [15:0]           dac_value,
    output logic [NUM_PAT*8-1:0]  trig_match,
    output logic [NUM_PAT*8-1:0]  trig_mask,
    output logic [7:0]            spi_mode
);
    localparam int QDEPTH = 1 << $clog2(2 * MAX_OPS);

    logic    push, commit, abort, head_valid;
    reg_op_t push_op, head_op;

    cfr_frame_parser #(.MAX_OPS(MAX_OPS)) u_parser (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .push     (push),
        .push_op  (push_op),
        .commit   (commit),
        .abort    (abort)
    );

    cfr_op_fifo #(.DEPTH(QDEPTH)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_op    (push_op),
        .commit     (commit),
        .abort      (abort),
        .pop        (head_valid),
        .head_valid (head_valid),
        .head_op    (head_op)
    );

    cfr_reg_file #(.NUM_PAT(NUM_PAT)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (head_valid),
        .op         (head_op),
        .status_in  (status_in),
        .ctl1       (ctl1),
        .ctl2       (ctl2),
        .clk_rate   (clk_rate),
        .dac_value  (dac_value),
        .trig_match (trig_match),
        .trig_mask  (trig_mask),
        .spi_mode   (spi_mode),
        .tx_valid   (tx_valid),
        .tx_byte    (tx_byte)
    );

endmodule

// File: tb/cmd_frame_rx_bench.sv
`timescale 1ns/1ps
module cmd_frame_rx_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic [7:0]  status_in = 8'h00;
    logic        tx_valid;
    logic [7:0]  tx_byte, ctl1, ctl2, spi_mode;
    logic [15:0] clk_rate, dac_value;
    logic [31:0] trig_match, trig_mask;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int tx_cnt = 0;
    bit started = 0;

    always #2.5 clk = ~clk;

    cmd_frame_rx u_cmd_frame_rx (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .status_in(status_in), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .ctl1(ctl1), .ctl2(ctl2), .clk_rate(clk_rate), .dac_value(dac_value),
        .trig_match(trig_match), .trig_mask(trig_mask), .spi_mode(spi_mode)
    );

    // ---------------- reference model (from the requirements) ----------
    logic [7:0]  sync_seq [5] = '{8'h40, 8'h4C, 8'h44, 8'h53, 8'h7E};
    int          m_hpos = 0;
    bit          m_inframe = 0, m_have_addr = 0;
    logic [7:0]  m_addr;
    logic [15:0] frame_q [$];
    logic [15:0] ready_q [$];
    logic [7:0]  m_ctl1, m_ctl2, m_rhi, m_rlo, m_dhi, m_dlo, m_mode, m_txb;
    logic [15:0] m_dac;
    logic [7:0]  m_match [4], m_mask [4];
    bit          m_txv;

    task automatic model_reset();
        m_hpos = 0; m_inframe = 0; m_have_addr = 0;
        frame_q.delete(); ready_q.delete();
        m_ctl1 = 0; m_ctl2 = 0; m_rhi = 0; m_rlo = 0; m_dhi = 0; m_dlo = 0;
        m_mode = 0; m_dac = 0; m_txv = 0; m_txb = 0;
        for (int i = 0; i < 4; i++) begin m_match[i] = 0; m_mask[i] = 0; end
    endtask

    task automatic model_apply(input logic [15:0] w);
        logic [7:0] a, d;
        a = w[15:8]; d = w[7:0];
        if (a == 8'h0F) m_ctl2 = d;
        else if (m_ctl2[1:0] == 2'd0) begin
            case (a)
                8'h02: begin m_txv = 1; m_txb = status_in; end
                8'h09: m_rhi = d;
                8'h0A: m_rlo = d;
                8'h0B: begin m_ctl1 = d; if (d[5]) m_dac = {m_dhi, m_dlo}; end
                8'h0C: m_dhi = d;
                8'h0D: m_dlo = d;
                default: ;
            endcase
        end else if (m_ctl2[1:0] == 2'd2) begin
            if (a < 4) m_match[a] = d;
            else if (a < 8) m_mask[a-4] = d;
            else if (a == 8) m_mode = d;
        end
    endtask

    task automatic model_byte(input logic [7:0] b);
        if (!m_inframe) begin
            if (b == sync_seq[m_hpos]) begin
                m_hpos++;
                if (m_hpos == 5) begin
                    m_inframe = 1; m_hpos = 0; m_have_addr = 0; frame_q.delete();
                end
            end else m_hpos = (b == 8'h40) ? 1 : 0;
        end else if (!m_have_addr) begin
            if (b == 8'h7E) begin
                foreach (frame_q[i]) ready_q.push_back(frame_q[i]);
                m_inframe = 0;
            end else if (frame_q.size() == 8) begin
                m_inframe = 0; frame_q.delete();
                m_hpos = (b == 8'h40) ? 1 : 0;
            end else begin
                m_addr = b; m_have_addr = 1;
            end
        end else begin
            frame_q.push_back({m_addr, b});
            m_have_addr = 0;
        end
    endtask

    // Model step on each rising edge: drain first, then take the byte
    always @(posedge clk) begin
        cycles++;
        started = 1;
        if (!rst_n) model_reset();
        else begin
            m_txv = 0;
            if (ready_q.size() > 0) model_apply(ready_q.pop_front());
            if (rx_valid) model_byte(rx_byte);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison at the falling edge
    always @(negedge clk) begin
        if (started) begin
            if (tx_valid === 1'b1) tx_cnt++;
            chk("R5 ctl2 vs model", {24'h0, ctl2}, {24'h0, m_ctl2});
            chk("R6 ctl1 vs model", {24'h0, ctl1}, {24'h0, m_ctl1});
            chk("R6 clk_rate vs model", {16'h0, clk_rate}, {16'h0, m_rhi, m_rlo});
            chk("R7 dac_value vs model", {16'h0, dac_value}, {16'h0, m_dac});
            chk("R8 trig_match vs model", trig_match,
                {m_match[3], m_match[2], m_match[1], m_match[0]});
            chk("R8 trig_mask vs model", trig_mask,
                {m_mask[3], m_mask[2], m_mask[1], m_mask[0]});
            chk("R8 spi_mode vs model", {24'h0, spi_mode}, {24'h0, m_mode});
            chk("R9 tx_valid vs model", {31'h0, tx_valid}, {31'h0, m_txv});
            if (m_txv) chk("R9 tx_byte vs model", {24'h0, tx_byte}, {24'h0, m_txb});
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cycles > 50000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=50000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic send_byte(input logic [7:0] b, input int gap);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        for (int i = 0; i < gap; i++) begin rx_valid = 1'b0; @(negedge clk); end
        rx_valid = 1'b0;
    endtask

    task automatic send_frame(input logic [15:0] ops [$], input int gap);
        for (int i = 0; i < 5; i++) send_byte(sync_seq[i], gap);
        foreach (ops[i]) begin
            send_byte(ops[i][15:8], gap);
            send_byte(ops[i][7:0], gap);
        end
        send_byte(8'h7E, gap);
    endtask

    task automatic settle();
        rx_valid = 1'b0;
        repeat (30) @(negedge clk);
    endtask

    initial begin
        int tx0;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 ctl2 reset", {24'h0, ctl2}, 32'h0);
        chk("R11 dac reset", {16'h0, dac_value}, 32'h0);
        chk("R11 tx_valid reset", {31'h0, tx_valid}, 32'h0);
        rst_n = 1'b1;
        settle();

        // R2 / R6: basic frame
        send_frame('{16'h0912, 16'h0A34, 16'h0B10}, 1);
        settle();
        chk("R6 clk_rate written", {16'h0, clk_rate}, 32'h1234);
        chk("R2 ctl1 written", {24'h0, ctl1}, 32'h10);

        // R7: staging does not move the DAC, load does
        send_frame('{16'h0CAB, 16'h0DCD}, 1);
        settle();
        chk("R7 dac unchanged after staging", {16'h0, dac_value}, 32'h0);
        send_frame('{16'h0B30}, 1);
        settle();
        chk("R7 dac loaded", {16'h0, dac_value}, 32'hABCD);

        // R5 / R8: bank switch inside a frame
        tx0 = tx_cnt;
        send_frame('{16'h0F02, 16'h0011, 16'h0122, 16'h0233, 16'h0344,
                     16'h04F0, 16'h070F, 16'h0803}, 1);
        settle();
        chk("R8 match bytes", trig_match, 32'h44332211);
        chk("R8 mask bytes", trig_mask, 32'h0F0000F0);
        chk("R8 mode byte", {24'h0, spi_mode}, 32'h03);
        chk("R8 bank0 untouched", {16'h0, clk_rate}, 32'h1234);
        chk("R5 no status read in bank 2", tx_cnt - tx0, 0);
        send_frame('{16'h0F00, 16'h0999}, 1);
        settle();
        chk("R5 back to bank 0", {16'h0, clk_rate}, 32'h9934);

        // R8: bank 1 ignores writes
        send_frame('{16'h0F01, 16'h0955, 16'h0B20, 16'h0F00}, 1);
        settle();
        chk("R8 bank 1 ignored rate", {16'h0, clk_rate}, 32'h9934);
        chk("R8 bank 1 ignored ctl1", {24'h0, ctl1}, 32'h30);

        // R9: two status reads
        status_in = 8'h25;
        tx0 = tx_cnt;
        send_frame('{16'h0200, 16'h02FF}, 1);
        settle();
        chk("R9 two reply bytes", tx_cnt - tx0, 2);

        // R1: noise, broken header, then header restarting on 0x40
        send_byte(8'h00, 1); send_byte(8'h7E, 1);
        send_byte(8'h40, 1); send_byte(8'h4C, 1); send_byte(8'h44, 1); send_byte(8'h00, 1);
        send_byte(8'h09, 1); send_byte(8'h77, 1); send_byte(8'h7E, 1);
        settle();
        chk("R1 broken header no effect", {16'h0, clk_rate}, 32'h9934);
        send_byte(8'h40, 1); send_byte(8'h4C, 1);
        send_byte(8'h40, 1); send_byte(8'h4C, 1); send_byte(8'h44, 1);
        send_byte(8'h53, 1); send_byte(8'h7E, 1);
        send_byte(8'h09, 1); send_byte(8'h01, 1);
        send_byte(8'h0A, 1); send_byte(8'h02, 1); send_byte(8'h7E, 1);
        settle();
        chk("R1 resync on 0x40", {16'h0, clk_rate}, 32'h0102);

        // R4: overlong frame is dropped
        for (int i = 0; i < 5; i++) send_byte(sync_seq[i], 1);
        for (int i = 0; i < 8; i++) begin send_byte(8'h09, 1); send_byte(8'hAA, 1); end
        send_byte(8'h0A, 1); send_byte(8'h55, 1); send_byte(8'h7E, 1);
        settle();
        chk("R4 aborted frame dropped", {16'h0, clk_rate}, 32'h0102);
        // R4: aborting byte 0x40 starts the next header
        for (int i = 0; i < 5; i++) send_byte(sync_seq[i], 1);
        for (int i = 0; i < 8; i++) begin send_byte(8'h0A, 1); send_byte(8'hBB, 1); end
        send_byte(8'h40, 1); send_byte(8'h4C, 1); send_byte(8'h44, 1);
        send_byte(8'h53, 1); send_byte(8'h7E, 1);
        send_byte(8'h09, 1); send_byte(8'h0C, 1);
        send_byte(8'h0A, 1); send_byte(8'h0D, 1); send_byte(8'h7E, 1);
        settle();
        chk("R4 abort byte starts header", {16'h0, clk_rate}, 32'h0C0D);

        // R10 / R3: back-to-back frames, a byte every cycle
        status_in = 8'h3C;
        tx0 = tx_cnt;
        send_frame('{16'h0200, 16'h0200, 16'h0200, 16'h0200,
                     16'h0C12, 16'h0D34, 16'h0B20, 16'h0900}, 0);
        send_frame('{}, 0);
        send_frame('{16'h095A, 16'h0AA5}, 0);
        settle();
        chk("R10 final rate", {16'h0, clk_rate}, 32'h5AA5);
        chk("R10 dac loaded", {16'h0, dac_value}, 32'h1234);
        chk("R3 ctl1 order", {24'h0, ctl1}, 32'h20);
        chk("R10 four replies", tx_cnt - tx0, 4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule